// File: doc/BRIEF.md
# Hash Job Command Intake

This block sits between a host core's custom-instruction port and a hashing accelerator. The host issues commands over a valid/ready handshake. Each command carries a small function code, two 64-bit operand words and a flag that asks for a completion response. The block decodes the function code and loads the operands into a job context: the message source address, the digest destination address and the message length. When the context is complete, it raises a context-valid flag. That flag is what allows the downstream fetch and permutation engines to begin.

Setting up a job takes two commands. The address command (function code 0) supplies both addresses. The length command (function code 1) supplies the length and launches the job. A length command that arrives before any addresses is dropped. While a job runs, the block refuses further commands so the context stays stable. A done pulse from the hash engine releases the context and reopens the command port. If the launching command asked for a response, that done pulse also produces a one-cycle response strobe toward the host.

Top module: `hash_cmd_intake`

## Requirements
- R1: After reset, `cmd_ready` is 1, `ctx_valid` is 0, `resp_valid` is 0, and the source, destination and length outputs are all zero.
- R2: An accepted command with function code 0 loads `ctx_src` from `cmd_op_a` and `ctx_dst` from `cmd_op_b`, visible in the cycle after acceptance. It does not raise `ctx_valid`.
- R3: An accepted command with function code 1, issued after an address command for the same job, loads `ctx_len` from `cmd_op_a`. It raises `ctx_valid` in the cycle after acceptance, and the context then shows the addresses and length of that job.
- R4: An accepted command with function code 1 and no address command since the last job end (or since reset) has no effect: `ctx_len` keeps its value and `ctx_valid` stays 0.
- R5: An accepted command with any function code other than 0 or 1 is consumed and has no effect on the context outputs or on `ctx_valid`.
- R6: While `ctx_valid` is 1, `cmd_ready` is 0 and no command is taken: `ctx_src`, `ctx_dst` and `ctx_len` hold steady until the job ends.
- R7: `eng_done` while `ctx_valid` is 1 clears `ctx_valid` and raises `cmd_ready` in the next cycle. It also discards the stored addresses, so a later job needs a fresh address command.
- R8: In the cycle after a done pulse ends a job, `resp_valid` is 1 for exactly one cycle if the job's length command had `cmd_want_resp` set. Otherwise `resp_valid` stays 0.
- R9: `eng_done` while no job is active has no effect: `resp_valid` stays 0 and `ctx_valid` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host presents a command |
| cmd_ready | output | 1 | Block can take a command this cycle |
| cmd_funct | input | FUNCT_W (7) | Function code: 0 = addresses, 1 = length and start |
| cmd_op_a | input | DATA_W (64) | First operand word |
| cmd_op_b | input | DATA_W (64) | Second operand word |
| cmd_want_resp | input | 1 | Command asks for a completion response |
| ctx_valid | output | 1 | Job context complete; engines may run |
| ctx_src | output | DATA_W (64) | Message source address |
| ctx_dst | output | DATA_W (64) | Digest destination address |
| ctx_len | output | DATA_W (64) | Message length |
| eng_done | input | 1 | Hash engine reports the job finished |
| resp_valid | output | 1 | One-cycle completion strobe to the host |

## Verification
The bench targets several corner cases:

- A length command with no addresses loaded. A design that starts anyway would launch a job with stale addresses.
- A length command issued right after a job ended. Here a design that kept the old addresses would restart the previous job.
- Commands held valid throughout a busy job. A design without back-pressure would overwrite the live context.
- Unknown function codes. These must not disturb the context.
- Done pulses with no job running, and jobs launched without a response request. In both cases a sloppy design would emit a spurious response strobe.

Each launched context is queued as an expected item and compared when `ctx_valid` rises. This also exercises zero-length jobs and all-ones operand values.

// File: rtl/hash_cmd_intake.sv
module hash_cmd_intake #(
  parameter int FUNCT_W = 7,
  parameter int DATA_W  = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [FUNCT_W-1:0] cmd_funct,
  input  logic [DATA_W-1:0]  cmd_op_a,
  input  logic [DATA_W-1:0]  cmd_op_b,
  input  logic               cmd_want_resp,
  output logic               ctx_valid,
  output logic [DATA_W-1:0]  ctx_src,
  output logic [DATA_W-1:0]  ctx_dst,
  output logic [DATA_W-1:0]  ctx_len,
  input  logic               eng_done,
  output logic               resp_valid
);

  localparam logic [FUNCT_W-1:0] FN_ADDR = FUNCT_W'(0);
  localparam logic [FUNCT_W-1:0] FN_LEN  = FUNCT_W'(1);

  logic addr_have;
  logic resp_req;

  wire take     = cmd_valid && cmd_ready;
  wire take_adr = take && (cmd_funct == FN_ADDR);
  wire take_len = take && (cmd_funct == FN_LEN);
  wire launch   = take_len && addr_have;
  wire finish   = ctx_valid && eng_done;

  assign cmd_ready = !ctx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_src <= '0;
      ctx_dst <= '0;
    end else if (take_adr) begin
      ctx_src <= cmd_op_a;
      ctx_dst <= cmd_op_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_len  <= '0;
      resp_req <= 1'b0;
    end else if (launch) begin
      ctx_len  <= cmd_op_a;
      resp_req <= cmd_want_resp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr_have <= 1'b0;
    else if (finish)   addr_have <= 1'b0;
    else if (take_adr) addr_have <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctx_valid <= 1'b0;
    else if (finish) ctx_valid <= 1'b0;
    else if (launch) ctx_valid <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resp_valid <= 1'b0;
    else        resp_valid <= finish && resp_req;
  end

endmodule

// File: rtl/hash_cmd_intake_chk.sv
module hash_cmd_intake_chk #(
  parameter int FUNCT_W = 7,
  parameter int DATA_W  = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [FUNCT_W-1:0] cmd_funct,
  input logic [DATA_W-1:0]  cmd_op_a,
  input logic [DATA_W-1:0]  cmd_op_b,
  input logic               cmd_want_resp,
  input logic               ctx_valid,
  input logic [DATA_W-1:0]  ctx_src,
  input logic [DATA_W-1:0]  ctx_dst,
  input logic [DATA_W-1:0]  ctx_len,
  input logic               eng_done,
  input logic               resp_valid,
  input logic               addr_have
);

  wire acc = cmd_valid && cmd_ready;

  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_funct == FUNCT_W'(0) |=> ctx_src == $past(cmd_op_a) && ctx_dst == $past(cmd_op_b) && !ctx_valid);

  // R3
  len_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_funct == FUNCT_W'(1) && addr_have |=> ctx_valid && ctx_len == $past(cmd_op_a));

  // R4
  len_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_funct == FUNCT_W'(1) && !addr_have |=> !ctx_valid && $stable(ctx_len));

  // R6
  ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_valid && !eng_done |=> ctx_valid && $stable(ctx_src) && $stable(ctx_dst) && $stable(ctx_len));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_valid && eng_done |=> !ctx_valid && cmd_ready && !addr_have);

  // R8
  resp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(ctx_valid && eng_done));

  // R9
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_valid && eng_done |=> !resp_valid);

  wire unused_ok = cmd_want_resp;

endmodule

bind hash_cmd_intake hash_cmd_intake_chk #(.FUNCT_W(FUNCT_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_funct(cmd_funct), .cmd_op_a(cmd_op_a), .cmd_op_b(cmd_op_b),
  .cmd_want_resp(cmd_want_resp), .ctx_valid(ctx_valid), .ctx_src(ctx_src),
  .ctx_dst(ctx_dst), .ctx_len(ctx_len), .eng_done(eng_done),
  .resp_valid(resp_valid), .addr_have(addr_have)
);

// File: tb/hash_cmd_intake_tb.sv
`timescale 1ns/1ps
module hash_cmd_intake_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [6:0]  cmd_funct = '0;
  logic [63:0] cmd_op_a = '0;
  logic [63:0] cmd_op_b = '0;
  logic        cmd_want_resp = 1'b0;
  logic        ctx_valid;
  logic [63:0] ctx_src, ctx_dst, ctx_len;
  logic        eng_done = 1'b0;
  logic        resp_valid;

  int checks = 0;
  int errors = 0;
  logic [191:0] exp_q[$];
  logic prev_valid = 1'b0;

  always #2.5 clk = ~clk;

  hash_cmd_intake dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_funct(cmd_funct), .cmd_op_a(cmd_op_a), .cmd_op_b(cmd_op_b),
    .cmd_want_resp(cmd_want_resp), .ctx_valid(ctx_valid), .ctx_src(ctx_src),
    .ctx_dst(ctx_dst), .ctx_len(ctx_len), .eng_done(eng_done),
    .resp_valid(resp_valid)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && ctx_valid && !prev_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected start", ctx_len, 64'h0);
      end else begin
        logic [191:0] e;
        e = exp_q.pop_front();
        check(ctx_src == e[191:128], "R3 src", ctx_src, e[191:128]);
        check(ctx_dst == e[127:64],  "R3 dst", ctx_dst, e[127:64]);
        check(ctx_len == e[63:0],    "R3 len", ctx_len, e[63:0]);
      end
    end
    prev_valid = ctx_valid;
  end

  task automatic send(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b, input logic r);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_funct = f; cmd_op_a = a; cmd_op_b = b; cmd_want_resp = r;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic start_job(input logic [63:0] s, input logic [63:0] d, input logic [63:0] l, input logic r);
    send(7'd0, s, d, 1'b0);
    exp_q.push_back({s, d, l});
    send(7'd1, l, 64'h0, r);
  endtask

  task automatic pulse_done();
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(cmd_ready == 1'b1, "R1 ready", 64'(cmd_ready), 64'h1);
    check(ctx_valid == 1'b0, "R1 valid", 64'(ctx_valid), 64'h0);
    check(resp_valid == 1'b0, "R1 resp", 64'(resp_valid), 64'h0);
    check(ctx_src == 0 && ctx_dst == 0 && ctx_len == 0, "R1 ctx", ctx_src | ctx_dst | ctx_len, 64'h0);
    rst_n = 1'b1;

    // R4: length with no addresses
    send(7'd1, 64'h55, 64'h0, 1'b1);
    check(ctx_valid == 1'b0, "R4 no start", 64'(ctx_valid), 64'h0);
    check(ctx_len == 64'h0, "R4 len kept", ctx_len, 64'h0);

    // R2
    send(7'd0, 64'h1000_0000_0000_00A0, 64'h2000_0000_0000_00B0, 1'b0);
    check(ctx_src == 64'h1000_0000_0000_00A0, "R2 src", ctx_src, 64'h1000_0000_0000_00A0);
    check(ctx_dst == 64'h2000_0000_0000_00B0, "R2 dst", ctx_dst, 64'h2000_0000_0000_00B0);
    check(ctx_valid == 1'b0, "R2 no start", 64'(ctx_valid), 64'h0);

    // R5
    send(7'd5, 64'hDEAD, 64'hBEEF, 1'b1);
    send(7'h7F, 64'hDEAD, 64'hBEEF, 1'b1);
    check(ctx_src == 64'h1000_0000_0000_00A0, "R5 src kept", ctx_src, 64'h1000_0000_0000_00A0);
    check(ctx_dst == 64'h2000_0000_0000_00B0, "R5 dst kept", ctx_dst, 64'h2000_0000_0000_00B0);
    check(ctx_valid == 1'b0 && ctx_len == 0, "R5 no start", ctx_len, 64'h0);

    // R3 via queue
    exp_q.push_back({64'h1000_0000_0000_00A0, 64'h2000_0000_0000_00B0, 64'd136});
    send(7'd1, 64'd136, 64'h0, 1'b1);
    check(ctx_valid == 1'b1, "R3 valid", 64'(ctx_valid), 64'h1);

    // R6: hold commands while busy
    check(cmd_ready == 1'b0, "R6 ready low", 64'(cmd_ready), 64'h0);
    cmd_valid = 1'b1; cmd_funct = 7'd0; cmd_op_a = 64'h9999; cmd_op_b = 64'h8888;
    repeat (4) @(negedge clk);
    cmd_valid = 1'b0;
    check(ctx_src == 64'h1000_0000_0000_00A0, "R6 src held", ctx_src, 64'h1000_0000_0000_00A0);
    check(ctx_dst == 64'h2000_0000_0000_00B0, "R6 dst held", ctx_dst, 64'h2000_0000_0000_00B0);
    check(ctx_len == 64'd136, "R6 len held", ctx_len, 64'd136);

    // R7, R8
    pulse_done();
    check(ctx_valid == 1'b0, "R7 valid cleared", 64'(ctx_valid), 64'h0);
    check(cmd_ready == 1'b1, "R7 ready back", 64'(cmd_ready), 64'h1);
    check(resp_valid == 1'b1, "R8 resp pulse", 64'(resp_valid), 64'h1);
    @(negedge clk);
    check(resp_valid == 1'b0, "R8 resp one cycle", 64'(resp_valid), 64'h0);

    // R7: addresses discarded
    send(7'd1, 64'd77, 64'h0, 1'b0);
    check(ctx_valid == 1'b0, "R7 needs new addr", 64'(ctx_valid), 64'h0);
    check(ctx_len == 64'd136, "R7 len kept", ctx_len, 64'd136);

    // R9
    pulse_done();
    check(resp_valid == 1'b0, "R9 idle done resp", 64'(resp_valid), 64'h0);
    check(ctx_valid == 1'b0, "R9 idle done valid", 64'(ctx_valid), 64'h0);

    // R8 no response requested; boundary values
    start_job('1, '1, 64'h0, 1'b0);
    check(ctx_valid == 1'b1, "R3 zero length start", 64'(ctx_valid), 64'h1);
    repeat (2) @(negedge clk);
    pulse_done();
    check(resp_valid == 1'b0, "R8 no resp", 64'(resp_valid), 64'h0);
    check(cmd_ready == 1'b1, "R7 ready after job2", 64'(cmd_ready), 64'h1);

    // back-to-back job right after release
    start_job(64'h0, 64'h40, '1, 1'b1);
    pulse_done();
    check(resp_valid == 1'b1, "R8 resp job3", 64'(resp_valid), 64'h1);

    @(negedge clk);
    check(exp_q.size() == 0, "R3 all jobs started", 64'(exp_q.size()), 64'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule